// File: doc/BRIEF.md
# Receive Frame Classifier and Status Builder

This block watches a received Ethernet frame as a byte stream, one byte per beat, marked with a start beat and an end beat. The byte count includes the trailing CRC bytes. Alongside the bytes it sees a receive-error flag on each beat. On the end beat it sees three verdicts computed elsewhere: CRC good, alignment error, and DMA overrun. From all of these it decides whether the frame is kept or dropped, and it builds a 13-bit receive status word.

The destination address (the first six bytes) is checked against a programmed station address, the broadcast address and the multicast group bit. A promiscuous switch lets every frame of six bytes or more through the address check. Frames shorter than 64 bytes are marked short. The 16-bit field at bytes 12 and 13 is classified as a type or as a length. Two saturating counters record short frames and frames that carried a receive error. A frame updates these counters whether or not it is kept.

The decision and the status word appear for exactly one cycle, in the cycle after the end beat. The configuration inputs are read in that same cycle.

Top module: `rxc_classifier`

## Requirements
- R1: A frame opens on a beat with `rx_sof` and closes on a beat with `rx_eof`; one beat may carry both. Beats outside a frame are ignored. `stat_valid` is high for exactly the one cycle after a closing beat. When `stat_valid` is low, `stat_accept` and `stat_word` are zero.
- R2: A frame passes the address check only if it has at least 6 bytes and at least one of these holds: the destination equals the station address, the destination is all ones, bit 0 of destination byte 0 is set while `mcast_all_en` is high, or `promisc_en` is high. Destination byte k is compared with `station_addr[8k+7:8k]`, and byte 0 is the first byte received.
- R3: Status bit 1 is 0 when the frame has at least 6 bytes and its destination equals the station address. Otherwise it is 1.
- R4: Status bit 2 is 1 when none of these match: the station address, broadcast, or multicast with `mcast_all_en` high.
- R5: Status bit 5 is 1 when the frame has at least 14 bytes and the value {byte12, byte13} is 0 or greater than 1500.
- R6: A frame is bad if its CRC is not good, if it had an overrun, if `rx_err` was seen on any of its beats, or if it is shorter than 64 bytes. `stat_accept` is 1 only if the frame passes R2, is not bad or `save_bad_en` is high, and is not both short and under `drop_short_en`.
- R7: The following error bits are set only while `save_bad_en` is high. Bit 11 is set for a CRC failure without an alignment error, and bit 10 for a CRC failure with one. Bit 8 is set for an overrun, bit 7 for a short frame, and bit 4 for a receive error seen. When `save_bad_en` is low, all of these bits are 0.
- R8: Status bits 12, 9, 6, 3 and 0 are always 0.
- R9: `short_cnt` rises by one for every closed frame shorter than 64 bytes, whether the frame is kept or dropped. The change takes effect at the clock edge that ends the valid cycle. The counter saturates at all ones.
- R10: `rxerr_cnt` rises by one, with the same timing and saturation as R9, for every closed frame in which `rx_err` was seen.
- R11: A start beat that arrives inside an open frame discards the partial frame and opens a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Symbol error reported on this byte |
| crc_ok | input | 1 | CRC verdict, read on the closing beat |
| align_err | input | 1 | Non-octet frame length, read on the closing beat |
| dma_overrun | input | 1 | Overrun verdict, read on the closing beat |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| promisc_en | input | 1 | Pass every destination |
| mcast_all_en | input | 1 | Pass every multicast destination |
| save_bad_en | input | 1 | Keep bad frames and report error bits |
| drop_short_en | input | 1 | Always drop frames under 64 bytes |
| stat_valid | output | 1 | Decision pulse |
| stat_accept | output | 1 | Keep the frame |
| stat_word | output | 13 | Receive status word |
| short_cnt | output | CNT_W | Short-frame counter |
| rxerr_cnt | output | CNT_W | Receive-error counter |

## Verification
The bench targets the type field at 1500 and 1501, and a 13-byte frame whose byte 12 is zero. A design that got the bound wrong would flag a valid length as a type, or would read a field that is not there. Multicast frames are sent with `mcast_all_en` both low and high, and a promiscuous-only frame is sent. These catch designs that invert bit 1, or that set bit 2 only when the frame is dropped.

Short and erroneous frames are sent under every combination of the save-bad and drop-short switches. A design that counted only kept frames, or that leaked error bits outside save-bad mode, would show a counter or status mismatch. Back-to-back frames, a one-byte frame, stray beats with no start, and a start inside an open frame expose designs that miss a pulse, mix state between frames, or keep a stale partial frame.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    localparam int STAT_W       = 13;
    localparam int DST_BYTES    = 6;
    localparam int MIN_FRAME    = 64;
    localparam int TL_POS       = 12;
    localparam int TL_LEN_LIMIT = 1500;

    localparam int SB_IA_MISS = 1;
    localparam int SB_NO_HIT  = 2;
    localparam int SB_RXERR   = 4;
    localparam int SB_TYPE    = 5;
    localparam int SB_SHORT   = 7;
    localparam int SB_OVERRUN = 8;
    localparam int SB_ALIGN   = 10;
    localparam int SB_CRC     = 11;

    typedef struct packed {
        logic ia_hit;
        logic bc_hit;
        logic mc_hit;
    } dst_match_t;
endpackage

// File: rtl/rxc_frame_track.sv
module rxc_frame_track #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_i,
    input  logic             sof_i,
    input  logic             eof_i,
    input  logic [7:0]       data_i,
    input  logic             err_i,
    input  logic             crc_ok_i,
    input  logic             align_i,
    input  logic             ovr_i,
    output logic             take_o,
    output logic [LEN_W-1:0] pos_o,
    output logic             done_o,
    output logic [LEN_W-1:0] len_o,
    output logic [15:0]      tfield_o,
    output logic             err_seen_o,
    output logic             crc_bad_o,
    output logic             align_o,
    output logic             ovr_o
);
    import rxc_pkg::*;

    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
    localparam logic [LEN_W-1:0] TL_HI   = LEN_W'(TL_POS);
    localparam logic [LEN_W-1:0] TL_LO   = LEN_W'(TL_POS + 1);

    typedef struct packed {
        logic             in_frame;
        logic             done;
        logic [LEN_W-1:0] len;
        logic [15:0]      tfield;
        logic             err_seen;
        logic             crc_bad;
        logic             align;
        logic             ovr;
    } trk_t;

    trk_t trk_d, trk_q;
    logic take;
    logic [LEN_W-1:0] pos;

    always_comb begin
        trk_d      = trk_q;
        trk_d.done = 1'b0;
        take       = beat_i && (sof_i || trk_q.in_frame);
        pos        = sof_i ? '0 : trk_q.len;
        if (take) begin
            if (sof_i) begin
                trk_d.err_seen = err_i;
                trk_d.tfield   = '0;
                trk_d.len      = LEN_W'(1);
            end else begin
                trk_d.err_seen = trk_q.err_seen | err_i;
                trk_d.len      = (trk_q.len == LEN_MAX) ? trk_q.len : trk_q.len + 1'b1;
            end
            if (pos == TL_HI) trk_d.tfield[15:8] = data_i;
            if (pos == TL_LO) trk_d.tfield[7:0]  = data_i;
            trk_d.in_frame = !eof_i;
            if (eof_i) begin
                trk_d.done    = 1'b1;
                trk_d.crc_bad = !crc_ok_i;
                trk_d.align   = align_i;
                trk_d.ovr     = ovr_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign take_o     = take;
    assign pos_o      = pos;
    assign done_o     = trk_q.done;
    assign len_o      = trk_q.len;
    assign tfield_o   = trk_q.tfield;
    assign err_seen_o = trk_q.err_seen;
    assign crc_bad_o  = trk_q.crc_bad;
    assign align_o    = trk_q.align;
    assign ovr_o      = trk_q.ovr;

    // R1: a closing beat inside a frame yields the decision pulse next cycle
    a_r1_done_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && eof_i && (sof_i || trk_q.in_frame)) |=> done_o);

    // R11: a start beat always restarts the byte count
    a_r11_restart_len: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && sof_i) |=> (len_o == LEN_W'(1)));
endmodule

// File: rtl/rxc_addr_match.sv
module rxc_addr_match #(
    parameter int LEN_W  = 12,
    parameter int NBYTES = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_i,
    input  logic [LEN_W-1:0]      pos_i,
    input  logic [7:0]            data_i,
    input  logic [LEN_W-1:0]      len_i,
    input  logic [8*NBYTES-1:0]   station_i,
    output rxc_pkg::dst_match_t   match_o
);
    import rxc_pkg::*;

    logic [NBYTES-1:0][7:0] dst_d, dst_q;
    logic enough;

    always_comb begin
        dst_d = dst_q;
        for (int k = 0; k < NBYTES; k++) begin
            if (take_i && pos_i == LEN_W'(k)) dst_d[k] = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dst_q <= '0;
        else        dst_q <= dst_d;
    end

    always_comb begin
        enough         = len_i >= LEN_W'(NBYTES);
        match_o.ia_hit = enough && (dst_q == station_i);
        match_o.bc_hit = enough && (&dst_q);
        match_o.mc_hit = enough && dst_q[0][0];
    end
endmodule

// File: rtl/rxc_status_build.sv
module rxc_status_build #(
    parameter int LEN_W = 12
) (
    input  rxc_pkg::dst_match_t       match_i,
    input  logic [LEN_W-1:0]          len_i,
    input  logic [15:0]               tfield_i,
    input  logic                      err_seen_i,
    input  logic                      crc_bad_i,
    input  logic                      align_i,
    input  logic                      ovr_i,
    input  logic                      promisc_i,
    input  logic                      mc_all_i,
    input  logic                      save_bad_i,
    input  logic                      drop_short_i,
    output logic [rxc_pkg::STAT_W-1:0] word_o,
    output logic                      accept_o,
    output logic                      short_o
);
    import rxc_pkg::*;

    localparam logic [LEN_W-1:0] LEN_MIN_ADDR = LEN_W'(DST_BYTES);
    localparam logic [LEN_W-1:0] LEN_MIN_TL   = LEN_W'(TL_POS + 2);
    localparam logic [LEN_W-1:0] LEN_MIN_OK   = LEN_W'(MIN_FRAME);

    logic filt_hit, addr_pass, is_short, is_bad, is_type;

    always_comb begin
        filt_hit  = match_i.ia_hit || match_i.bc_hit || (match_i.mc_hit && mc_all_i);
        addr_pass = (len_i >= LEN_MIN_ADDR) && (filt_hit || promisc_i);
        is_short  = len_i < LEN_MIN_OK;
        is_bad    = crc_bad_i || ovr_i || err_seen_i || is_short;
        is_type   = (len_i >= LEN_MIN_TL) &&
                    ((tfield_i == 16'd0) || (tfield_i > 16'(TL_LEN_LIMIT)));

        accept_o  = addr_pass && !(is_short && drop_short_i) && (save_bad_i || !is_bad);
        short_o   = is_short;

        word_o             = '0;
        word_o[SB_IA_MISS] = !match_i.ia_hit;
        word_o[SB_NO_HIT]  = !filt_hit;
        word_o[SB_TYPE]    = is_type;
        word_o[SB_RXERR]   = save_bad_i && err_seen_i;
        word_o[SB_SHORT]   = save_bad_i && is_short;
        word_o[SB_OVERRUN] = save_bad_i && ovr_i;
        word_o[SB_ALIGN]   = save_bad_i && crc_bad_i && align_i;
        word_o[SB_CRC]     = save_bad_i && crc_bad_i && !align_i;
    end
endmodule

// File: rtl/rxc_classifier.sv
module rxc_classifier #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic              rx_err,
    input  logic              crc_ok,
    input  logic              align_err,
    input  logic              dma_overrun,
    input  logic [47:0]       station_addr,
    input  logic              promisc_en,
    input  logic              mcast_all_en,
    input  logic              save_bad_en,
    input  logic              drop_short_en,
    output logic              stat_valid,
    output logic              stat_accept,
    output logic [12:0]       stat_word,
    output logic [CNT_W-1:0]  short_cnt,
    output logic [CNT_W-1:0]  rxerr_cnt
);
    import rxc_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] short_c;
        logic [CNT_W-1:0] err_c;
    } cnt_t;

    logic             take, done, err_seen, crc_bad, align, ovr;
    logic [LEN_W-1:0] pos, len;
    logic [15:0]      tfield;
    dst_match_t       match;
    logic [STAT_W-1:0] word;
    logic             accept, is_short;
    cnt_t             cnt_d, cnt_q;

    rxc_frame_track #(.LEN_W(LEN_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_i     (rx_valid),
        .sof_i      (rx_sof),
        .eof_i      (rx_eof),
        .data_i     (rx_data),
        .err_i      (rx_err),
        .crc_ok_i   (crc_ok),
        .align_i    (align_err),
        .ovr_i      (dma_overrun),
        .take_o     (take),
        .pos_o      (pos),
        .done_o     (done),
        .len_o      (len),
        .tfield_o   (tfield),
        .err_seen_o (err_seen),
        .crc_bad_o  (crc_bad),
        .align_o    (align),
        .ovr_o      (ovr)
    );

    rxc_addr_match #(.LEN_W(LEN_W), .NBYTES(DST_BYTES)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .pos_i     (pos),
        .data_i    (rx_data),
        .len_i     (len),
        .station_i (station_addr),
        .match_o   (match)
    );

    rxc_status_build #(.LEN_W(LEN_W)) u_stat (
        .match_i      (match),
        .len_i        (len),
        .tfield_i     (tfield),
        .err_seen_i   (err_seen),
        .crc_bad_i    (crc_bad),
        .align_i      (align),
        .ovr_i        (ovr),
        .promisc_i    (promisc_en),
        .mc_all_i     (mcast_all_en),
        .save_bad_i   (save_bad_en),
        .drop_short_i (drop_short_en),
        .word_o       (word),
        .accept_o     (accept),
        .short_o      (is_short)
    );

    always_comb begin
        cnt_d = cnt_q;
        if (done) begin
            if (is_short && cnt_q.short_c != CNT_MAX) cnt_d.short_c = cnt_q.short_c + 1'b1;
            if (err_seen && cnt_q.err_c != CNT_MAX)   cnt_d.err_c   = cnt_q.err_c + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign stat_valid  = done;
    assign stat_accept = done && accept;
    assign stat_word   = done ? word : '0;
    assign short_cnt   = cnt_q.short_c;
    assign rxerr_cnt   = cnt_q.err_c;

    // R2: a kept frame is at least one full destination long
    a_r2_accept_len: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_accept) |-> (len >= LEN_W'(DST_BYTES)));

    // R3: a station-address hit is also a filter hit
    a_r3_ia_implies_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_word[SB_IA_MISS]) |-> !stat_word[SB_NO_HIT]);

    // R6: short frames never survive the drop-short switch
    a_r6_drop_short: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && drop_short_en && len < LEN_W'(MIN_FRAME)) |-> !stat_accept);

    // R7: no error bit leaks outside save-bad mode
    a_r7_err_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !save_bad_en) |->
        (!stat_word[SB_CRC] && !stat_word[SB_ALIGN] && !stat_word[SB_OVERRUN] &&
         !stat_word[SB_SHORT] && !stat_word[SB_RXERR]));

    // R9: the short counter moves only at the end of a valid cycle
    a_r9_short_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(short_cnt) |-> $past(stat_valid));

    // R10: the receive-error counter moves only at the end of a valid cycle
    a_r10_err_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rxerr_cnt) |-> $past(stat_valid));
endmodule

// File: tb/test_rxc_classifier.sv
module test_rxc_classifier;
    localparam int CLK_P = 10;
    localparam int CW    = 3;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic crc_ok = 1'b1, align_err = 1'b0, dma_overrun = 1'b0;
    logic [47:0] station_addr = 48'h6655_4433_2210;
    logic promisc_en = 1'b0, mcast_all_en = 1'b0, save_bad_en = 1'b0, drop_short_en = 1'b0;
    logic stat_valid, stat_accept;
    logic [12:0] stat_word;
    logic [CW-1:0] short_cnt, rxerr_cnt;

    rxc_classifier #(.LEN_W(12), .CNT_W(CW)) i_rxc_classifier (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .rx_err(rx_err), .crc_ok(crc_ok), .align_err(align_err),
        .dma_overrun(dma_overrun), .station_addr(station_addr), .promisc_en(promisc_en),
        .mcast_all_en(mcast_all_en), .save_bad_en(save_bad_en), .drop_short_en(drop_short_en),
        .stat_valid(stat_valid), .stat_accept(stat_accept), .stat_word(stat_word),
        .short_cnt(short_cnt), .rxerr_cnt(rxerr_cnt)
    );

    always #(CLK_P/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit mon_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference model state
    logic [7:0] cur[$];
    bit in_fr = 1'b0, err_acc = 1'b0;
    bit exp_v = 1'b0, exp_acc = 1'b0, exp_short = 1'b0, exp_rxe = 1'b0;
    logic [12:0] exp_word = '0;
    int m_short = 0, m_rxe = 0, nvalid = 0;
    bit last_acc = 1'b0;
    logic [12:0] last_word = '0;

    function automatic void predict(input bit crcb, input bit alg, input bit ovr);
        int n;
        bit ia, bc, mc, hit, pass, shrt, badf, typ;
        int tl;
        n  = cur.size();
        ia = (n >= 6);
        bc = (n >= 6);
        if (n >= 6) begin
            for (int k = 0; k < 6; k++) begin
                if (cur[k] != station_addr[8*k +: 8]) ia = 1'b0;
                if (cur[k] != 8'hff) bc = 1'b0;
            end
        end
        mc   = (n >= 6) && cur[0][0];
        hit  = ia || bc || (mc && mcast_all_en);
        pass = (n >= 6) && (hit || promisc_en);
        shrt = (n < 64);
        badf = crcb || ovr || err_acc || shrt;
        tl   = (n >= 14) ? {cur[12], cur[13]} : 1;
        typ  = (n >= 14) && (tl == 0 || tl > 1500);
        exp_acc   = pass && !(shrt && drop_short_en) && (save_bad_en || !badf);
        exp_short = shrt;
        exp_rxe   = err_acc;
        exp_word  = '0;
        exp_word[1]  = !ia;
        exp_word[2]  = !hit;
        exp_word[5]  = typ;
        exp_word[4]  = save_bad_en && err_acc;
        exp_word[7]  = save_bad_en && shrt;
        exp_word[8]  = save_bad_en && ovr;
        exp_word[10] = save_bad_en && crcb && alg;
        exp_word[11] = save_bad_en && crcb && !alg;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            in_fr = 1'b0; exp_v = 1'b0; m_short = 0; m_rxe = 0; cur.delete();
        end else begin
            if (exp_v) begin
                if (exp_short && m_short < CMAX) m_short++;
                if (exp_rxe && m_rxe < CMAX) m_rxe++;
            end
            exp_v = 1'b0;
            if (rx_valid) begin
                if (rx_sof) begin
                    cur.delete(); in_fr = 1'b1; err_acc = 1'b0;
                end
                if (in_fr) begin
                    cur.push_back(rx_data);
                    err_acc = err_acc | rx_err;
                    if (rx_eof) begin
                        predict(!crc_ok, align_err, dma_overrun);
                        exp_v = 1'b1;
                        in_fr = 1'b0;
                    end
                end
            end
        end
    end

    // per-cycle comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && mon_on) begin
            chk(stat_valid == exp_v, "R1", "valid", stat_valid, exp_v);
            if (exp_v && stat_valid) begin
                nvalid++;
                last_acc  = stat_accept;
                last_word = stat_word;
                chk(stat_accept == exp_acc, "R2/R6", "accept", stat_accept, exp_acc);
                chk(stat_word[1] == exp_word[1], "R3", "ia-miss bit", stat_word[1], exp_word[1]);
                chk(stat_word[2] == exp_word[2], "R4", "no-hit bit", stat_word[2], exp_word[2]);
                chk(stat_word[5] == exp_word[5], "R5", "type bit", stat_word[5], exp_word[5]);
                chk((stat_word & 13'h0D90) == (exp_word & 13'h0D90), "R7", "error bits",
                    stat_word & 13'h0D90, exp_word & 13'h0D90);
                chk((stat_word & 13'h1249) == 0, "R8", "reserved bits", stat_word & 13'h1249, 0);
            end
            if (!stat_valid) begin
                chk(stat_word == 0 && stat_accept == 0, "R1", "idle outputs",
                    {stat_accept, stat_word}, 0);
            end
            chk(int'(short_cnt) == m_short, "R9", "short counter", short_cnt, m_short);
            chk(int'(rxerr_cnt) == m_rxe, "R10", "rx error counter", rxerr_cnt, m_rxe);
        end
    end

    task automatic beat(input logic [7:0] d, input bit s, input bit e, input bit er);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_sof = s; rx_eof = e; rx_err = er;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
        end
    endtask

    task automatic frame(input logic [47:0] dst, input logic [15:0] tl, input int n,
                         input int err_at, input bit b2b);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            if (i < 6)       b = dst[8*i +: 8];
            else if (i < 12) b = 8'hA0 + 8'(i);
            else if (i == 12) b = tl[15:8];
            else if (i == 13) b = tl[7:0];
            else             b = 8'(i);
            beat(b, i == 0, i == n - 1, i == err_at);
        end
        if (!b2b) idle(3);
    endtask

    task automatic chk_last(input string tag, input bit acc, input logic [12:0] w);
        chk(last_acc == acc, tag, "directed accept", last_acc, acc);
        chk(last_word == w, tag, "directed word", last_word, w);
    endtask

    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCAST = 48'h0000_0000_0001;
    localparam logic [47:0] OTHER = 48'h0000_0000_0042;

    initial begin
        int nv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat_valid == 0, "R1", "reset valid", stat_valid, 0);
        chk(short_cnt == 0, "R9", "reset short counter", short_cnt, 0);
        chk(rxerr_cnt == 0, "R10", "reset rx error counter", rxerr_cnt, 0);
        mon_on = 1'b1;

        frame(station_addr, 16'h0800, 64, -1, 0);
        chk_last("R2", 1, 13'h020);
        frame(BCAST, 16'd100, 70, -1, 0);
        frame(MCAST, 16'd100, 64, -1, 0);
        chk_last("R2", 0, 13'h006);
        mcast_all_en = 1'b1;
        frame(MCAST, 16'd100, 64, -1, 0);
        chk_last("R4", 1, 13'h002);
        mcast_all_en = 1'b0;
        frame(OTHER, 16'd100, 64, -1, 0);
        chk_last("R2", 0, 13'h006);
        promisc_en = 1'b1;
        frame(OTHER, 16'd100, 64, -1, 0);
        chk_last("R4", 1, 13'h006);
        frame(station_addr, 16'd100, 5, -1, 0);
        chk_last("R2", 0, 13'h006);
        save_bad_en = 1'b1;
        frame(OTHER, 16'h0000, 13, -1, 0);
        chk_last("R5", 1, 13'h086);
        save_bad_en = 1'b0;
        promisc_en = 1'b0;

        frame(station_addr, 16'd0, 64, -1, 0);
        chk_last("R5", 1, 13'h020);
        frame(station_addr, 16'd1500, 64, -1, 0);
        chk_last("R5", 1, 13'h000);
        frame(station_addr, 16'd1501, 64, -1, 0);
        chk_last("R5", 1, 13'h020);

        frame(station_addr, 16'd100, 40, -1, 0);
        chk_last("R6", 0, 13'h000);
        save_bad_en = 1'b1;
        frame(station_addr, 16'd100, 40, -1, 0);
        chk_last("R7", 1, 13'h080);
        drop_short_en = 1'b1;
        frame(station_addr, 16'd100, 40, -1, 0);
        chk_last("R6", 0, 13'h080);
        drop_short_en = 1'b0;

        frame(station_addr, 16'd100, 64, 20, 0);
        chk_last("R7", 1, 13'h010);
        save_bad_en = 1'b0;
        frame(station_addr, 16'd100, 64, 30, 0);
        chk_last("R6", 0, 13'h000);
        save_bad_en = 1'b1;
        crc_ok = 1'b0;
        frame(station_addr, 16'd100, 64, -1, 0);
        chk_last("R7", 1, 13'h800);
        align_err = 1'b1;
        frame(station_addr, 16'd100, 64, -1, 0);
        chk_last("R7", 1, 13'h400);
        crc_ok = 1'b1;
        frame(station_addr, 16'd100, 64, -1, 0);
        chk_last("R7", 1, 13'h000);
        align_err = 1'b0;
        dma_overrun = 1'b1;
        frame(station_addr, 16'd100, 64, -1, 0);
        chk_last("R7", 1, 13'h100);
        save_bad_en = 1'b0;
        frame(station_addr, 16'd100, 64, -1, 0);
        chk_last("R6", 0, 13'h000);
        dma_overrun = 1'b0;

        nv = nvalid;
        for (int i = 0; i < 10; i++) beat(8'(i), 1'b0, i == 9, 1'b0);
        idle(3);
        chk(nvalid == nv, "R1", "stray beats ignored", nvalid, nv);

        for (int i = 0; i < 10; i++) beat(8'h42, i == 0, 1'b0, 1'b0);
        frame(station_addr, 16'h0800, 64, -1, 0);
        chk_last("R11", 1, 13'h020);

        nv = nvalid;
        frame(station_addr, 16'd100, 64, -1, 1);
        beat(8'h10, 1'b1, 1'b1, 1'b0);
        frame(BCAST, 16'h0800, 66, -1, 0);
        chk(nvalid == nv + 3, "R1", "back-to-back pulses", nvalid, nv + 3);

        for (int i = 0; i < 9; i++) frame(station_addr, 16'd100, 20, 3, 0);
        chk(int'(short_cnt) == CMAX, "R9", "short counter saturates", short_cnt, CMAX);
        chk(int'(rxerr_cnt) == CMAX, "R10", "rx error counter saturates", rxerr_cnt, CMAX);

        idle(2);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule